// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is a chip-level control register for a bus-attached test device. It gives software two writable flags, an interrupt enable and an interrupt request. Raising the request with the enable set makes the chip signal the host through an active-low status line.

The register is 32 bits wide and is seen as two 16-bit halves at consecutive word addresses. Only three bits of the low half carry meaning. Bit 0 is the enable. Bit 1 is the request. Bit 2 is a read-only copy of their AND. The active-low status output is the inverse of that AND. All other bits read as zero.

The slave interface is synchronous. A write is taken on a rising clock edge when the strobe is high and the address equals the low-half address exactly. Read data is combinational from the address, and the status line follows the stored bits.

Top module: `irq_csr_top`

## Requirements
- R1: After reset, enable and request are 0, the low half reads 0x0000 and `stat_n` is 1.
- R2: A strobed write to word address 0 loads bit 0 of the write data into the enable flag, which reads back at bit 0 of address 0.
- R3: A strobed write to word address 0 loads bit 1 of the write data into the request flag, which reads back at bit 1 of address 0.
- R4: Bit 2 of address 0 reads as (enable AND request), and write data bit 2 has no effect on any stored state.
- R5: `stat_n` equals the inverse of bit 2 of address 0. It changes in the cycle after the clock edge that takes the write.
- R6: Bits 15:3 of address 0 and all bits of address 1 read as 0, and writing ones to them changes nothing.
- R7: A strobed write to any address other than 0 (including 1) leaves enable and request unchanged.
- R8: With the write strobe low, no input pattern changes enable or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for the current address, combinational |
| stat_n | output | 1 | Active-low interrupt status toward the host interface |

## Verification
Read data is due in the same cycle as the address, because no register lies on the read path. A write shows up in read data and in `stat_n` one clock edge after the strobe is sampled. The bench therefore compares the read value of each new address shortly after driving it and before the edge. After the edge, it advances its reference model and compares read data and `stat_n` at the following falling edge. Every step compares both outputs, so each write or non-write is checked at the exact cycle where its effect is due.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
    localparam int EN_BIT   = 0;
    localparam int REQ_BIT  = 1;
    localparam int STAT_BIT = 2;

    typedef struct packed {
        logic req;
        logic en;
    } csr_bits_t;
endpackage

// File: rtl/irq_csr_dec.sv
module irq_csr_dec #(
    parameter int ADDR_W  = 8,
    parameter int LO_ADDR = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              wr_lo,
    output logic              sel_lo,
    output logic              sel_hi
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LO_ADDR + 1);

    always_comb begin
        sel_lo = (addr == LO_A);
        sel_hi = (addr == HI_A);
        wr_lo  = wr && sel_lo;
    end
endmodule

// File: rtl/irq_csr_bits.sv
module irq_csr_bits
    import irq_csr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    output csr_bits_t         bits_q
);
    csr_bits_t bits_d;
    logic      unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:STAT_BIT];

    always_comb begin
        bits_d = bits_q;
        if (wr_lo) begin
            bits_d.en  = wdata[EN_BIT];
            bits_d.req = wdata[REQ_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    // R7 and R8: state moves only on a decoded low-half write
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(bits_q));
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> bits_q.en == $past(wdata[EN_BIT]));
    a_r3_request_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> bits_q.req == $past(wdata[REQ_BIT]));
endmodule

// File: rtl/irq_csr_view.sv
module irq_csr_view
    import irq_csr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo,
    input  logic              sel_hi,
    input  csr_bits_t         bits_q,
    output logic [DATA_W-1:0] rdata,
    output logic              stat_n
);
    logic stat;

    always_comb begin
        stat   = bits_q.en & bits_q.req;
        stat_n = ~stat;
        rdata  = '0;
        if (sel_lo) begin
            rdata[EN_BIT]   = bits_q.en;
            rdata[REQ_BIT]  = bits_q.req;
            rdata[STAT_BIT] = stat;
        end else if (sel_hi) begin
            rdata = '0;
        end
    end

    a_r6_high_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |-> rdata == '0);
    a_r6_low_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lo |-> rdata[DATA_W-1:STAT_BIT+1] == '0);
    a_r4_status_is_and: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lo |-> rdata[STAT_BIT] == (rdata[EN_BIT] & rdata[REQ_BIT]));
endmodule

// File: rtl/irq_csr_top.sv
module irq_csr_top
    import irq_csr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LO_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stat_n
);
    logic      wr_lo;
    logic      sel_lo;
    logic      sel_hi;
    csr_bits_t bits_q;

    irq_csr_dec #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) dec_i (
        .addr(bus_addr), .wr(bus_wr),
        .wr_lo(wr_lo), .sel_lo(sel_lo), .sel_hi(sel_hi)
    );

    irq_csr_bits #(.DATA_W(DATA_W)) bits_i (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo),
        .wdata(bus_wdata), .bits_q(bits_q)
    );

    irq_csr_view #(.DATA_W(DATA_W)) view_i (
        .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .bits_q(bits_q), .rdata(bus_rdata), .stat_n(stat_n)
    );

    // R5: outgoing line is the inverse of the readable status bit
    a_r5_line_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(LO_ADDR)) |-> stat_n == !bus_rdata[STAT_BIT]);
endmodule

// File: tb/irq_csr_top_tb_top.sv
module irq_csr_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        stat_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_en = 0;
    int m_req = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_csr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_n(stat_n)
    );

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        logic [15:0] v = '0;
        if (a == 8'd0) begin
            v[0] = m_en[0];
            v[1] = m_req[0];
            v[2] = m_en[0] & m_req[0];
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=0x%04h expected=0x%04h", tag, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " read"}, bus_rdata, exp_read(bus_addr));
        check("R5 stat_n", {15'd0, stat_n}, {15'd0, !(m_en[0] & m_req[0])});
    endtask

    // drive one cycle, compare before and after the edge
    task automatic step(input string tag, input logic [7:0] a, input logic w, input logic [15:0] d);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        #1;
        compare_all(tag);
        @(posedge clk);
        if (rst_n && w && a == 8'd0) begin
            m_en  = int'(d[0]);
            m_req = int'(d[1]);
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state while held
        bus_addr = 8'd0; #1;
        check("R1 reset read", bus_rdata, 16'h0000);
        check("R1 reset stat_n", {15'd0, stat_n}, 16'h0001);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1", 8'd0, 1'b0, 16'h0000);
        step("R2", 8'd0, 1'b1, 16'h0001);
        check("R2 enable bit", bus_rdata, 16'h0001);
        step("R3", 8'd0, 1'b1, 16'h0003);
        check("R5 asserted low", {15'd0, stat_n}, 16'h0000);
        step("R6", 8'd0, 1'b1, 16'hFFFF);
        check("R6 spare bits", bus_rdata, 16'h0007);
        step("R6 high", 8'd1, 1'b1, 16'hFFFF);
        check("R6 high half", bus_rdata, 16'h0000);
        step("R7", 8'd1, 1'b1, 16'h0000);
        step("R7", 8'd2, 1'b1, 16'h0000);
        step("R7", 8'd128, 1'b1, 16'h0000);
        step("R7", 8'd255, 1'b1, 16'h0000);
        step("R7 readback", 8'd0, 1'b0, 16'h0000);
        check("R7 state kept", bus_rdata, 16'h0007);
        step("R8", 8'd0, 1'b0, 16'h0000);
        step("R8", 8'd0, 1'b0, 16'hFFFC);
        check("R8 no strobe", bus_rdata, 16'h0007);
        step("R3", 8'd0, 1'b1, 16'h0002);
        check("R3 request only", bus_rdata, 16'h0002);
        check("R5 deasserted", {15'd0, stat_n}, 16'h0001);
        step("R4", 8'd0, 1'b1, 16'h0004);
        check("R4 bit2 write ignored", bus_rdata, 16'h0000);
        step("R2", 8'd0, 1'b1, 16'h0001);
        step("R5", 8'd0, 1'b1, 16'h0003);
        step("R5", 8'd0, 1'b1, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            step("R7 sweep", 8'(i), 1'b1, 16'(i * 16'h1111));
        end
        // R1: reset during operation
        step("R1 pre", 8'd0, 1'b1, 16'h0003);
        rst_n = 1'b0; m_en = 0; m_req = 0;
        #1;
        check("R1 async reset read", bus_rdata, 16'h0000);
        check("R1 async reset stat_n", {15'd0, stat_n}, 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 post", 8'd0, 1'b0, 16'h0000);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule